// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Receiver

This block sits on the device side of a byte-wide configuration port. An external agent owns the configuration clock and drives an active-low select, an active-low write strobe and eight data pins. On each rising edge where select and strobe are both low and the block is not signalling busy, the block takes one byte. It turns the pin order around, because the agent places the most significant bit of every byte on data pin 0. It then hands the byte to a downstream byte stream through a valid/ready handshake.

Backpressure from the stream reaches the agent through the busy output. A busy agent holds its byte on the pins, and the byte is taken on the first rising edge after busy falls. If the agent releases the write strobe while select stays low during a write sequence, the block aborts. Abort handling lasts a fixed, parameterised number of cycles. During that time busy stays high, any byte still waiting in the output register is dropped, and the pins are ignored. A one-cycle pulse marks the end of the abort. The write sequence ends when the agent raises select.

Top module: `cfg_byte_rx`

## Requirements
- R1: While reset is held, and on the first cycle after it, `byte_valid` and `abort_done` are 0 and `cfg_busy` equals the inverse of `byte_ready`.
- R2: Take a rising edge where `cfg_cs_n`=0, `cfg_wr_n`=0 and `cfg_busy`=0. After that edge, `byte_valid`=1 and `byte_data[7-k]` equals `cfg_d[k]` for every k from 0 to 7. Pin 0 therefore carries the MSB.
- R3: While `cfg_cs_n`=1, no byte is taken, whatever the value of `cfg_wr_n`.
- R4: Outside abort handling, `cfg_busy` is exactly the inverse of `byte_ready`.
- R5: A byte held on the pins while `cfg_busy`=1 is not taken during that time. It is taken on the first rising edge at which `cfg_busy` is 0.
- R6: While `byte_valid`=1 and `byte_ready`=0, and no abort starts, `byte_valid` stays 1 and `byte_data` does not change.
- R7: An abort starts on an edge where the block is inside a write sequence, with `cfg_cs_n`=0 and `cfg_wr_n`=1. After that edge, `cfg_busy` is 1 for exactly ABORT_CYCLES cycles.
- R8: The edge that starts an abort clears `byte_valid` and drops the pending byte. No byte is taken while the abort runs, even with select and strobe low.
- R9: `abort_done` is 1 for exactly one cycle: the first cycle after abort handling ends.
- R10: Once `cfg_cs_n` has risen and ended a sequence, `cfg_cs_n`=0 with `cfg_wr_n`=1 starts no abort until a new sequence has begun with both pins low.
- R11: When `byte_valid`=1 and `byte_ready`=1 and no new byte is taken on the same edge, `byte_valid` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the external agent |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cs_n | input | 1 | Active-low select |
| cfg_wr_n | input | 1 | Active-low write strobe |
| cfg_d | input | 8 | Data pins; pin 0 carries the MSB |
| cfg_busy | output | 1 | Throttle to the agent; high means hold the data |
| abort_done | output | 1 | One-cycle pulse after abort handling finishes |
| byte_data | output | 8 | Received byte in normal bit order |
| byte_valid | output | 1 | Downstream byte valid |
| byte_ready | input | 1 | Downstream ready |

## Verification
The bench sends every one of the 256 byte values through the pins. A receiver that does not reverse the lanes, or reverses only part of them, gives wrong bytes for almost all of those values. Stalls are the next target. A held byte must be taken exactly once, on the edge after busy falls: a design that samples a cycle early loses a byte, and one that samples a cycle late duplicates it. The output byte must not change while the stream stalls. Abort timing is checked cycle by cycle. Getting it wrong shows up as busy dropping one cycle too early or too late, a stale byte left valid, bytes leaking in during the abort, or a done pulse that is missing or too long. The bench also covers the release of the strobe after select has already ended the sequence, which must not trigger an abort.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE   = 2'd0,
    RX_ACTIVE = 2'd1,
    RX_ABORT  = 2'd2
  } rx_state_t;

  // both active-low controls asserted: a byte is being offered
  function automatic logic is_write(input logic cs_n, input logic wr_n);
    return (!cs_n) && (!wr_n);
  endfunction

  // select held but strobe released: abort request inside a sequence
  function automatic logic is_abort_req(input logic cs_n, input logic wr_n);
    return (!cs_n) && wr_n;
  endfunction

endpackage

// File: rtl/cfg_rx_lane_swap.sv
module cfg_rx_lane_swap #(
  parameter int W = 8
) (
  input  logic [W-1:0] pins,
  output logic [W-1:0] word
);
  // pin 0 carries the MSB, so lane k maps to bit W-1-k
  for (genvar k = 0; k < W; k++) begin : g_lane
    assign word[W-1-k] = pins[k];
  end
endmodule

// File: rtl/cfg_rx_seq.sv
module cfg_rx_seq
  import cfg_rx_pkg::*;
#(
  parameter int ABORT_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic wr_n,
  output logic abort_start,
  output logic abort_busy,
  output logic abort_done
);
  localparam int CW = (ABORT_CYCLES > 1) ? $clog2(ABORT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(ABORT_CYCLES - 1);

  rx_state_t     state_q, state_d;
  logic [CW-1:0] cnt_q;
  logic          done_q;
  logic          abort_end;

  assign abort_start = (state_q == RX_ACTIVE) && is_abort_req(cs_n, wr_n);
  assign abort_busy  = (state_q == RX_ABORT);
  assign abort_end   = abort_busy && (cnt_q == LAST);
  assign abort_done  = done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RX_IDLE:   if (is_write(cs_n, wr_n)) state_d = RX_ACTIVE;
      RX_ACTIVE: if (cs_n) state_d = RX_IDLE;
                 else if (abort_start) state_d = RX_ABORT;
      RX_ABORT:  if (abort_end) state_d = RX_IDLE;
      default:   state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= abort_end;
      if (abort_start)     cnt_q <= '0;
      else if (abort_busy) cnt_q <= cnt_q + 1'b1;
    end
  end

  // R7: the window opened by an abort stays busy until its count is used up
  assert_abort_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_start |=> abort_busy);
  assert_abort_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_busy && !abort_end) |=> abort_busy);
  // R9: completion is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_done |=> !abort_done);
endmodule

// File: rtl/cfg_rx_outreg.sv
module cfg_rx_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         flush,
  input  logic [W-1:0] din,
  input  logic         ready,
  output logic [W-1:0] dout,
  output logic         valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      dout  <= '0;
    end else if (flush) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      dout  <= din;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  // R6: a stalled byte keeps its value
  assert_stall_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !flush) |=> (valid && $stable(dout)));
  // R8: a flush leaves nothing pending
  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !valid);
endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx
  import cfg_rx_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ABORT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cs_n,
  input  logic              cfg_wr_n,
  input  logic [DATA_W-1:0] cfg_d,
  output logic              cfg_busy,
  output logic              abort_done,
  output logic [DATA_W-1:0] byte_data,
  output logic              byte_valid,
  input  logic              byte_ready
);
  logic              abort_start;
  logic              abort_busy;
  logic              take_byte;
  logic [DATA_W-1:0] swapped;

  cfg_rx_lane_swap #(.W(DATA_W)) u_swap (
    .pins (cfg_d),
    .word (swapped)
  );

  cfg_rx_seq #(.ABORT_CYCLES(ABORT_CYCLES)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cfg_cs_n),
    .wr_n        (cfg_wr_n),
    .abort_start (abort_start),
    .abort_busy  (abort_busy),
    .abort_done  (abort_done)
  );

  assign cfg_busy  = abort_busy || !byte_ready;
  assign take_byte = is_write(cfg_cs_n, cfg_wr_n) && !cfg_busy;

  cfg_rx_outreg #(.W(DATA_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take_byte),
    .flush (abort_start),
    .din   (swapped),
    .ready (byte_ready),
    .dout  (byte_data),
    .valid (byte_valid)
  );

  // R3: a new byte only ever follows an edge with select and strobe low
  assert_rise_needs_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_valid) |-> $past(!cfg_cs_n && !cfg_wr_n));
  // R4: backpressure reaches the agent
  assert_busy_on_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_ready |-> cfg_busy);
  // R8: nothing becomes valid straight out of an abort cycle
  assert_no_take_in_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_busy |=> !$rose(byte_valid));
endmodule

// File: tb/sim_cfg_byte_rx.sv
module sim_cfg_byte_rx;
  localparam int NAB = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_n, ready;
  logic [7:0] d;
  logic       busy, adone, valid;
  logic [7:0] q;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  cfg_byte_rx #(.DATA_W(8), .ABORT_CYCLES(NAB)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_cs_n(cs_n), .cfg_wr_n(wr_n), .cfg_d(d),
    .cfg_busy(busy), .abort_done(adone), .byte_data(q), .byte_valid(valid),
    .byte_ready(ready)
  );

  function automatic logic [7:0] mirror(input logic [7:0] v);
    logic [7:0] r = 8'd0;
    for (int k = 0; k < 8; k++) r = r | (8'(v[k]) << (7 - k));
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] a, b, c;
    rst_n = 0; cs_n = 1; wr_n = 1; ready = 1; d = 8'h00;
    repeat (3) step();
    chk("R1 valid in reset", valid, 0);
    chk("R1 done in reset", adone, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1;
    step();
    chk("R1 valid after reset", valid, 0);
    chk("R1 done after reset", adone, 0);

    // R2: sweep all byte values, one per edge
    cs_n = 0; wr_n = 0;
    for (int v = 0; v < 256; v++) begin
      d = 8'(v);
      chk("R4 busy while ready", busy, 0);
      step();
      chk("R2 valid", valid, 1);
      chk("R2 reversed data", q, mirror(8'(v)));
    end

    // R3 / R11: select high blocks intake, old byte drains
    cs_n = 1;
    for (int w = 0; w < 2; w++) begin
      wr_n = 1'(w); d = 8'hA5;
      step();
      chk("R3 R11 no intake with select high", valid, 0);
    end

    // R4: busy follows ready
    ready = 0; #1;
    chk("R4 busy when not ready", busy, 1);
    ready = 1; #1;
    chk("R4 busy clears", busy, 0);

    // R5 / R6: stall with a held byte
    a = 8'h1E; b = 8'hC3;
    cs_n = 0; wr_n = 0; d = a;
    step();
    chk("R2 byte A", q, mirror(a));
    ready = 0; d = b;
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R6 valid held", valid, 1);
      chk("R6 data held", q, mirror(a));
      chk("R5 busy during hold", busy, 1);
    end
    ready = 1;
    step();
    chk("R5 held byte taken", q, mirror(b));
    chk("R5 valid after release", valid, 1);
    cs_n = 1; wr_n = 1;
    step();
    chk("R11 drained", valid, 0);

    // R7 / R8 / R9: abort with a pending byte
    c = 8'h81;
    cs_n = 0; wr_n = 0; d = c;
    step();
    chk("R2 byte C", q, mirror(c));
    ready = 0; wr_n = 1;
    step();                            // abort edge E0
    chk("R8 pending byte dropped", valid, 0);
    chk("R7 busy after E0", busy, 1);
    ready = 1; wr_n = 0; d = 8'h7F;    // offer a byte during the abort
    for (int i = 1; i < NAB; i++) begin
      step();
      chk("R7 busy during abort", busy, 1);
      chk("R8 no intake during abort", valid, 0);
      chk("R9 no early done", adone, 0);
    end
    cs_n = 1; wr_n = 1;
    step();                            // edge that ends the abort
    chk("R7 busy ends", busy, 0);
    chk("R9 done pulse", adone, 1);
    chk("R8 nothing taken", valid, 0);
    step();
    chk("R9 pulse one cycle", adone, 0);

    // R10: strobe high with select low after a finished sequence
    cs_n = 0; wr_n = 1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk("R10 no abort busy", busy, 0);
      chk("R10 no done", adone, 0);
    end
    step();
    chk("R10 no done later", adone, 0);
    cs_n = 1;
    step();
    finish_run();
  end
endmodule